// File: doc/BRIEF.md
# Instruction Line Fetch and Slot Extraction

This block sits between a thread's program counter and the decode stage. For each requested fetch it checks a private 64-byte line buffer kept per hardware thread. On a hit it cuts a group of 32-bit instruction words out of the buffered line and presents them as a slot array towards decode. On a miss it asks an instruction memory port for the aligned line and refills the buffer when the matching response comes back.

The memory port may turn a request away. The rejected request then waits in a single retry slot shared by all threads, and the port counts as blocked until a retry pulse gets it accepted or a squash releases it. Each request carries a thread index and a sequence tag. A response is used only if its thread is still waiting and the tag matches; any other response is dropped and counted. A squash returns a thread to idle and frees the retry slot if that thread owns it.

The fetch stream uses valid/ready. `fetch_valid` asks for thread `fetch_tid` at `fetch_pc`. `out_valid` rises in the same cycle when the line is present. A transfer happens when `out_valid` and `out_ready` are both high, and `fetch_ready` reports it. Upstream must hold its request, including the predicted-taken flags, until `fetch_ready` is seen. While `out_ready` is low the slot outputs hold steady. The memory request is a one-cycle offer: `mem_req_valid` with `mem_req_ready` low counts as a rejection, not as a stall.

Top module: `ifetch_line_unit`

## Requirements
- R1: A memory request carries the fetch PC with its low 6 bits cleared as `mem_req_addr` and the requesting thread on `mem_req_tid`.
- R2: When the thread's buffer holds a valid line whose block address equals the aligned fetch PC, no memory request is made and `out_valid` is high in the same cycle.
- R3: A miss on an idle thread, with the port not blocked, makes a request in that cycle. When the matching response arrives, the line is stored and later fetches hit. Word j of a line sits at data bits 32j+31..32j.
- R4: A request offered while `mem_req_ready` is low is kept in the retry slot, and `port_blocked` is high from the next cycle. While blocked, no new request is offered; only a retry may use the port.
- R5: A `mem_retry` pulse re-offers the held request with the same address, thread and tag. If it is accepted, `port_blocked` clears. If no request is held, `mem_retry` offers nothing.
- R6: A response for a thread that is not waiting, or with a tag other than the thread's outstanding one, leaves the line unchanged and adds one to `drop_count`.
- R7: A squash of a thread releases that thread's held retry request and clears `port_blocked`. A response still in flight for that thread becomes stale, and the next fetch misses again.
- R8: Slot i holds the word at index `fetch_pc[5:2]`+i of the line, with slot PC `{fetch_pc[31:2],2'b00}`+4i.
- R9: `out_count` is the smallest of three limits: the fetch width, the words left in the line, and one past the first slot whose `pred_taken` bit is set. `out_taken_stop` is high when that last limit ended the group.
- R10: `out_next_pc` equals the word-aligned fetch PC plus 4 times `out_count`.
- R11: `fetch_ready` is high exactly when `out_valid` and `out_ready` are both high. With `out_ready` low the group is not consumed.
- R12: After reset no line is valid, `out_valid`, `mem_req_valid` and `port_blocked` are low, and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch group consumed this cycle |
| fetch_tid | input | TID_W | Requesting thread |
| fetch_pc | input | ADDR_W | Fetch PC |
| pred_taken | input | FETCH_W | Predicted-taken flag per slot |
| squash_valid | input | 1 | Squash a thread |
| squash_tid | input | TID_W | Thread to squash |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the offer |
| mem_req_addr | output | ADDR_W | Line-aligned address |
| mem_req_tid | output | TID_W | Request thread |
| mem_req_tag | output | SEQ_W | Request sequence tag |
| mem_retry | input | 1 | Port may take the held request |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_tid | input | TID_W | Response thread |
| mem_rsp_tag | input | SEQ_W | Response sequence tag |
| mem_rsp_data | input | 512 | Line data |
| out_valid | output | 1 | Slot group valid |
| out_ready | input | 1 | Decode accepts the group |
| out_tid | output | TID_W | Thread of the group |
| out_count | output | CNT_W | Number of valid slots |
| out_words | output | FETCH_W*32 | Instruction words, slot i at bits 32i |
| out_pcs | output | FETCH_W*ADDR_W | Slot PCs |
| out_next_pc | output | ADDR_W | Sequential PC after the group |
| out_taken_stop | output | 1 | Group ended on a predicted-taken slot |
| port_blocked | output | 1 | Retry slot in use |
| drop_count | output | DROP_W | Count of discarded responses |

## Verification
The bench builds the block with two threads and a fetch width of four. Two threads let one thread's rejected request block another thread's miss, and let a stale response aimed at one thread be checked against the untouched line of the same thread. A width of four, below the sixteen words of a line, makes all three limits reachable: width, line end near offset 13 or 15, and a taken flag in an inner slot. The random phase mixes the start offsets, flag patterns and rejections across four lines.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  localparam int LINE_WORDS = 16;
  localparam int LINE_BITS  = LINE_WORDS * 32;
  localparam int OFS_W      = 6;
  typedef enum logic [1:0] {
    TH_IDLE       = 2'd0,
    TH_WAIT_RSP   = 2'd1,
    TH_WAIT_RETRY = 2'd2
  } th_state_e;
endpackage

// File: rtl/ifl_thread_lines.sv
module ifl_thread_lines #(
  parameter int NTHR  = 2,
  parameter int TID_W = 1,
  parameter int BLK_W = 26,
  parameter int SEQ_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          iss_fire,
  input  logic                          iss_acc,
  input  logic [TID_W-1:0]              iss_tid,
  input  logic [BLK_W-1:0]              iss_blk,
  input  logic [SEQ_W-1:0]              iss_seq,
  input  logic                          rty_acc,
  input  logic [TID_W-1:0]              rty_tid,
  input  logic                          fill_en,
  input  logic [TID_W-1:0]              fill_tid,
  input  logic [ifl_pkg::LINE_BITS-1:0] fill_data,
  input  logic                          sq_en,
  input  logic [TID_W-1:0]              sq_tid,
  output ifl_pkg::th_state_e            st_o     [NTHR],
  output logic [NTHR-1:0]               vld_o,
  output logic [BLK_W-1:0]              blk_o    [NTHR],
  output logic [SEQ_W-1:0]              seq_o    [NTHR],
  output logic [ifl_pkg::LINE_BITS-1:0] dat_o    [NTHR]
);
  import ifl_pkg::*;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    localparam logic [TID_W-1:0] MY_TID = TID_W'(t);
    th_state_e              st_q;
    logic                   vld_q;
    logic [BLK_W-1:0]       blk_q;
    logic [SEQ_W-1:0]       seq_q;
    logic [LINE_BITS-1:0]   dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= TH_IDLE;
        vld_q <= 1'b0;
        blk_q <= '0;
        seq_q <= '0;
      end else if (sq_en && sq_tid == MY_TID) begin
        st_q <= TH_IDLE;
      end else if (iss_fire && iss_tid == MY_TID) begin
        vld_q <= 1'b0;
        blk_q <= iss_blk;
        seq_q <= iss_seq;
        st_q  <= iss_acc ? TH_WAIT_RSP : TH_WAIT_RETRY;
      end else if (rty_acc && rty_tid == MY_TID) begin
        st_q <= TH_WAIT_RSP;
      end else if (fill_en && fill_tid == MY_TID) begin
        vld_q <= 1'b1;
        st_q  <= TH_IDLE;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_tid == MY_TID) dat_q <= fill_data;
    end

    assign st_o[t]  = st_q;
    assign vld_o[t] = vld_q;
    assign blk_o[t] = blk_q;
    assign seq_o[t] = seq_q;
    assign dat_o[t] = dat_q;
  end
endmodule

// File: rtl/ifl_port_ctrl.sv
module ifl_port_ctrl #(
  parameter int TID_W = 1,
  parameter int BLK_W = 26,
  parameter int SEQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_vld,
  input  logic [TID_W-1:0] want_tid,
  input  logic [BLK_W-1:0] want_blk,
  input  logic             mem_req_ready,
  input  logic             mem_retry,
  input  logic             sq_en,
  input  logic [TID_W-1:0] sq_tid,
  output logic             req_vld,
  output logic [BLK_W-1:0] req_blk,
  output logic [TID_W-1:0] req_tid,
  output logic [SEQ_W-1:0] req_seq,
  output logic             iss_fire,
  output logic             iss_acc,
  output logic             rty_acc,
  output logic [TID_W-1:0] rty_tid,
  output logic             blocked_o
);
  logic             blocked_q, held_q;
  logic [TID_W-1:0] h_tid_q;
  logic [BLK_W-1:0] h_blk_q;
  logic [SEQ_W-1:0] h_seq_q, seq_cnt_q;
  logic             sq_held, rty_send;

  assign sq_held  = sq_en && held_q && sq_tid == h_tid_q;
  assign rty_send = blocked_q && mem_retry && held_q && !sq_held;
  assign iss_fire = want_vld && !blocked_q;
  assign iss_acc  = iss_fire && mem_req_ready;
  assign rty_acc  = rty_send && mem_req_ready;
  assign rty_tid  = h_tid_q;
  assign blocked_o = blocked_q;

  always_comb begin
    req_vld = rty_send || iss_fire;
    if (rty_send) begin
      req_blk = h_blk_q;
      req_tid = h_tid_q;
      req_seq = h_seq_q;
    end else begin
      req_blk = want_blk;
      req_tid = want_tid;
      req_seq = seq_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked_q <= 1'b0;
      held_q    <= 1'b0;
      h_tid_q   <= '0;
      h_blk_q   <= '0;
      h_seq_q   <= '0;
      seq_cnt_q <= '0;
    end else begin
      if (iss_fire) begin
        seq_cnt_q <= seq_cnt_q + 1'b1;
        if (!mem_req_ready) begin
          held_q    <= 1'b1;
          blocked_q <= 1'b1;
          h_tid_q   <= want_tid;
          h_blk_q   <= want_blk;
          h_seq_q   <= seq_cnt_q;
        end
      end
      if (rty_acc || sq_held) begin
        held_q    <= 1'b0;
        blocked_q <= 1'b0;
      end
      if (blocked_q && mem_retry && !held_q) blocked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ifl_extract.sv
module ifl_extract #(
  parameter int FETCH_W = 4,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 3
) (
  input  logic [ifl_pkg::LINE_BITS-1:0] line,
  input  logic [ADDR_W-1:0]             pc,
  input  logic [FETCH_W-1:0]            taken,
  output logic [CNT_W-1:0]              cnt,
  output logic [FETCH_W*32-1:0]         words,
  output logic [FETCH_W*ADDR_W-1:0]     pcs,
  output logic [ADDR_W-1:0]             next_pc,
  output logic                          taken_stop
);
  import ifl_pkg::*;
  logic [3:0]        w0;
  logic [ADDR_W-1:0] base;
  logic [1:0]        unused_lo;
  int                room;
  logic              stop;

  assign w0        = pc[5:2];
  assign base      = {pc[ADDR_W-1:2], 2'b00};
  assign unused_lo = pc[1:0];
  assign room      = LINE_WORDS - int'(w0);

  always_comb begin
    cnt  = '0;
    stop = 1'b0;
    for (int i = 0; i < FETCH_W; i++) begin
      if (!stop && i < room) begin
        cnt = CNT_W'(i + 1);
        if (taken[i]) stop = 1'b1;
      end
    end
  end

  assign taken_stop = stop;
  assign next_pc    = base + (ADDR_W'(cnt) << 2);

  for (genvar s = 0; s < FETCH_W; s++) begin : g_slot
    logic [3:0] wi;
    assign wi = w0 + 4'(s);
    assign words[s*32 +: 32] = (s < int'(cnt)) ? line[{wi, 5'b0} +: 32] : 32'h0;
    assign pcs[s*ADDR_W +: ADDR_W] = base + ADDR_W'(4 * s);
  end
endmodule

// File: rtl/ifetch_line_unit.sv
module ifetch_line_unit #(
  parameter int NTHR    = 2,
  parameter int FETCH_W = 4,
  parameter int ADDR_W  = 32,
  parameter int SEQ_W   = 4,
  parameter int DROP_W  = 16,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetch_valid,
  output logic                          fetch_ready,
  input  logic [TID_W-1:0]              fetch_tid,
  input  logic [ADDR_W-1:0]             fetch_pc,
  input  logic [FETCH_W-1:0]            pred_taken,
  input  logic                          squash_valid,
  input  logic [TID_W-1:0]              squash_tid,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [ADDR_W-1:0]             mem_req_addr,
  output logic [TID_W-1:0]              mem_req_tid,
  output logic [SEQ_W-1:0]              mem_req_tag,
  input  logic                          mem_retry,
  input  logic                          mem_rsp_valid,
  input  logic [TID_W-1:0]              mem_rsp_tid,
  input  logic [SEQ_W-1:0]              mem_rsp_tag,
  input  logic [ifl_pkg::LINE_BITS-1:0] mem_rsp_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [TID_W-1:0]              out_tid,
  output logic [CNT_W-1:0]              out_count,
  output logic [FETCH_W*32-1:0]         out_words,
  output logic [FETCH_W*ADDR_W-1:0]     out_pcs,
  output logic [ADDR_W-1:0]             out_next_pc,
  output logic                          out_taken_stop,
  output logic                          port_blocked,
  output logic [DROP_W-1:0]             drop_count
);
  import ifl_pkg::*;
  localparam int BLK_W = ADDR_W - OFS_W;

  th_state_e              st     [NTHR];
  logic [NTHR-1:0]        vld;
  logic [BLK_W-1:0]       blk    [NTHR];
  logic [SEQ_W-1:0]       pseq   [NTHR];
  logic [LINE_BITS-1:0]   dat    [NTHR];

  logic [BLK_W-1:0] f_blk, req_blk;
  logic             sq_f, hit, want;
  logic             iss_fire, iss_acc, rty_acc;
  logic [TID_W-1:0] rty_tid;
  logic             sq_r, rsp_ok;
  logic [DROP_W-1:0] drop_q;

  assign f_blk = fetch_pc[ADDR_W-1:OFS_W];
  assign sq_f  = squash_valid && squash_tid == fetch_tid;
  assign hit   = vld[fetch_tid] && blk[fetch_tid] == f_blk;
  assign want  = fetch_valid && !hit && !sq_f && st[fetch_tid] == TH_IDLE;

  assign out_valid   = fetch_valid && hit && !sq_f;
  assign fetch_ready = out_valid && out_ready;
  assign out_tid     = fetch_tid;

  assign sq_r   = squash_valid && squash_tid == mem_rsp_tid;
  assign rsp_ok = mem_rsp_valid && !sq_r && st[mem_rsp_tid] == TH_WAIT_RSP
                  && mem_rsp_tag == pseq[mem_rsp_tid];

  ifl_port_ctrl #(.TID_W(TID_W), .BLK_W(BLK_W), .SEQ_W(SEQ_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .want_vld(want), .want_tid(fetch_tid), .want_blk(f_blk),
    .mem_req_ready(mem_req_ready), .mem_retry(mem_retry),
    .sq_en(squash_valid), .sq_tid(squash_tid),
    .req_vld(mem_req_valid), .req_blk(req_blk), .req_tid(mem_req_tid),
    .req_seq(mem_req_tag), .iss_fire(iss_fire), .iss_acc(iss_acc),
    .rty_acc(rty_acc), .rty_tid(rty_tid), .blocked_o(port_blocked)
  );
  assign mem_req_addr = {req_blk, {OFS_W{1'b0}}};

  ifl_thread_lines #(.NTHR(NTHR), .TID_W(TID_W), .BLK_W(BLK_W), .SEQ_W(SEQ_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .iss_fire(iss_fire), .iss_acc(iss_acc), .iss_tid(fetch_tid),
    .iss_blk(f_blk), .iss_seq(mem_req_tag),
    .rty_acc(rty_acc), .rty_tid(rty_tid),
    .fill_en(rsp_ok), .fill_tid(mem_rsp_tid), .fill_data(mem_rsp_data),
    .sq_en(squash_valid), .sq_tid(squash_tid),
    .st_o(st), .vld_o(vld), .blk_o(blk), .seq_o(pseq), .dat_o(dat)
  );

  ifl_extract #(.FETCH_W(FETCH_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ext (
    .line(dat[fetch_tid]), .pc(fetch_pc), .taken(pred_taken),
    .cnt(out_count), .words(out_words), .pcs(out_pcs),
    .next_pc(out_next_pc), .taken_stop(out_taken_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= '0;
    else if (mem_rsp_valid && !rsp_ok) drop_q <= drop_q + 1'b1;
  end
  assign drop_count = drop_q;
endmodule

// File: rtl/ifl_line_unit_chk.sv
module ifl_line_unit_chk #(
  parameter int FETCH_W = 4,
  parameter int ADDR_W  = 32,
  parameter int DROP_W  = 16,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  fetch_pc,
  input logic [FETCH_W-1:0] pred_taken,
  input logic               fetch_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               mem_retry,
  input logic               mem_rsp_valid,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CNT_W-1:0]   out_count,
  input logic               out_taken_stop,
  input logic               port_blocked,
  input logic [DROP_W-1:0]  drop_count
);
  // R1
  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[5:0] == 6'd0);
  // R4
  a_r4_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    port_blocked && !mem_retry |-> !mem_req_valid);
  a_r4_block_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_blocked) |-> $past(mem_req_valid && !mem_req_ready));
  // R6
  a_r6_drop_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count != $past(drop_count) |-> $past(mem_rsp_valid));
  // R9
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count != '0 && int'(out_count) <= FETCH_W);
  a_r9_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(fetch_pc[5:2]) + int'(out_count) <= 16);
  a_r9_taken_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken_stop |-> pred_taken[out_count - 1'b1]);
  // R11
  a_r11_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> out_valid && out_ready);
endmodule

bind ifetch_line_unit ifl_line_unit_chk #(
  .FETCH_W(FETCH_W), .ADDR_W(ADDR_W), .DROP_W(DROP_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/ifetch_line_unit_test.sv
module ifetch_line_unit_test;
  localparam int FW = 4;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic fetch_valid = 0, fetch_ready;
  logic [0:0] fetch_tid = 0;
  logic [31:0] fetch_pc = 0;
  logic [FW-1:0] pred_taken = 0;
  logic squash_valid = 0;
  logic [0:0] squash_tid = 0;
  logic mem_req_valid, mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic [0:0] mem_req_tid;
  logic [3:0] mem_req_tag;
  logic mem_retry = 0, mem_rsp_valid = 0;
  logic [0:0] mem_rsp_tid = 0;
  logic [3:0] mem_rsp_tag = 0;
  logic [511:0] mem_rsp_data = 0;
  logic out_valid, out_ready = 1;
  logic [0:0] out_tid;
  logic [2:0] out_count;
  logic [FW*32-1:0] out_words;
  logic [FW*32-1:0] out_pcs;
  logic [31:0] out_next_pc;
  logic out_taken_stop, port_blocked;
  logic [15:0] drop_count;

  ifetch_line_unit uut (.*);

  int n_run = 0, n_fail = 0, exp_drop = 0;
  logic [3:0] tag_c;

  function automatic logic [31:0] wexp(logic [31:0] a, int j);
    return ({a[31:6], 6'b0} | 32'(j)) ^ 32'hC300_0000;
  endfunction
  function automatic logic [511:0] lexp(logic [31:0] a);
    logic [511:0] d;
    for (int j = 0; j < 16; j++) d[j*32 +: 32] = wexp(a, j);
    return d;
  endfunction
  function automatic int cexp(logic [31:0] pc, logic [FW-1:0] p);
    int c = 0;
    for (int i = 0; i < FW; i++) begin
      if (int'(pc[5:2]) + i >= 16) break;
      c = i + 1;
      if (p[i]) break;
    end
    return c;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 0; pred_taken = 0; squash_valid = 0; mem_retry = 0;
    mem_rsp_valid = 0; mem_req_ready = 1; out_ready = 1;
  endtask

  task automatic respond(logic [0:0] t, logic [3:0] tg, logic [31:0] a);
    @(negedge clk);
    idle();
    mem_rsp_valid = 1; mem_rsp_tid = t; mem_rsp_tag = tg; mem_rsp_data = lexp(a);
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 0;
  endtask

  // make line present; rej forces one rejection then a retry
  task automatic fill(logic [0:0] t, logic [31:0] pc, bit rej);
    @(negedge clk);
    idle();
    fetch_valid = 1; fetch_tid = t; fetch_pc = pc; mem_req_ready = !rej;
    #2;
    if (mem_req_valid) begin
      chk("R1 addr", mem_req_addr, {pc[31:6], 6'b0});
      chk("R1 tid", 32'(mem_req_tid), 32'(t));
      tag_c = mem_req_tag;
      @(posedge clk);
      if (rej) begin
        @(negedge clk);
        idle(); mem_retry = 1;
        #2;
        chk("R5 resend tag", {27'd0, mem_req_valid, mem_req_tag}, {27'd0, 1'b1, tag_c});
        @(posedge clk);
      end
      respond(t, tag_c, pc);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic look(logic [0:0] t, logic [31:0] pc, logic [FW-1:0] p);
    int c;
    c = cexp(pc, p);
    @(negedge clk);
    idle();
    fetch_valid = 1; fetch_tid = t; fetch_pc = pc; pred_taken = p;
    #2;
    chk("R2 hit valid", {30'd0, out_valid, mem_req_valid}, 32'h2);
    chk("R9 count", 32'(out_count), 32'(c));
    chk("R9 taken stop", 32'(out_taken_stop), 32'(p[c-1]));
    chk("R10 next pc", out_next_pc, {pc[31:2], 2'b00} + 32'(4 * c));
    for (int i = 0; i < c; i++) begin
      chk("R8 word", out_words[i*32 +: 32], wexp(pc, int'(pc[5:2]) + i));
      chk("R8 pc", out_pcs[i*32 +: 32], {pc[31:2], 2'b00} + 32'(4 * i));
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    // R12 reset state
    chk("R12 reset", {28'd0, out_valid, mem_req_valid, port_blocked, 1'b0}, 32'd0);
    chk("R12 drop", 32'(drop_count), 0);
    rst_n = 1;

    // R3 miss then refill
    fill(0, 32'h1000_0048, 0);
    look(0, 32'h1000_0048, 4'b0000);
    look(0, 32'h1000_007C, 4'b0000);   // R9 line end: one slot
    look(0, 32'h1000_0074, 4'b0000);   // R9 line end: three slots
    look(0, 32'h1000_0040, 4'b0010);   // R9 taken in slot 1

    // R11 back-pressure
    @(negedge clk);
    idle(); fetch_valid = 1; fetch_tid = 0; fetch_pc = 32'h1000_0040; out_ready = 0;
    #2;
    chk("R11 not consumed", {30'd0, out_valid, fetch_ready}, 32'h2);
    out_ready = 1;
    #1;
    chk("R11 consumed", 32'(fetch_ready), 1);

    // R4 rejection blocks the port
    @(negedge clk);
    idle(); fetch_valid = 1; fetch_tid = 1; fetch_pc = 32'h2000_0004; mem_req_ready = 0;
    #2;
    tag_c = mem_req_tag;
    chk("R4 offered", 32'(mem_req_valid), 1);
    @(posedge clk);
    @(negedge clk);
    idle(); fetch_valid = 1; fetch_tid = 0; fetch_pc = 32'h3000_0000;
    #2;
    chk("R4 blocked", 32'(port_blocked), 1);
    chk("R4 no new request", 32'(mem_req_valid), 0);
    @(posedge clk);
    @(negedge clk);
    idle(); mem_retry = 1;
    #2;
    chk("R5 resend addr", mem_req_addr, 32'h2000_0000);
    chk("R5 resend tid/tag", {27'd0, mem_req_tid, mem_req_tag}, {27'd0, 1'b1, tag_c});
    @(posedge clk);
    @(negedge clk);
    idle();
    #2;
    chk("R5 unblocked", 32'(port_blocked), 0);
    respond(1, tag_c, 32'h2000_0000);
    look(1, 32'h2000_0004, 4'b0000);

    // R6 stale response leaves line alone
    @(negedge clk);
    idle(); mem_rsp_valid = 1; mem_rsp_tid = 0; mem_rsp_tag = tag_c + 4'd5; mem_rsp_data = '1;
    @(posedge clk);
    @(negedge clk);
    idle(); exp_drop++;
    #2;
    chk("R6 drop count", 32'(drop_count), 32'(exp_drop));
    look(0, 32'h1000_0048, 4'b0000);

    // R7 squash releases held retry
    @(negedge clk);
    idle(); fetch_valid = 1; fetch_tid = 1; fetch_pc = 32'h4000_0000; mem_req_ready = 0;
    @(posedge clk);
    @(negedge clk);
    idle(); squash_valid = 1; squash_tid = 1;
    @(posedge clk);
    @(negedge clk);
    idle();
    #2;
    chk("R7 unblocked", 32'(port_blocked), 0);
    mem_retry = 1;
    #1;
    chk("R5 empty retry", 32'(mem_req_valid), 0);
    @(posedge clk);

    // R7 squash makes in-flight response stale
    @(negedge clk);
    idle(); fetch_valid = 1; fetch_tid = 0; fetch_pc = 32'h5000_0000;
    #2;
    tag_c = mem_req_tag;
    @(posedge clk);
    @(negedge clk);
    idle(); squash_valid = 1; squash_tid = 0;
    @(posedge clk);
    respond(0, tag_c, 32'h5000_0000);
    exp_drop++;
    #2;
    chk("R7 stale drop", 32'(drop_count), 32'(exp_drop));
    fetch_valid = 1; fetch_tid = 0; fetch_pc = 32'h5000_0000;
    #1;
    chk("R7 refetch misses", {30'd0, out_valid, mem_req_valid}, 32'h1);
    fetch_valid = 0;
    #1;

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [0:0] t;
      logic [31:0] pc;
      logic [FW-1:0] p;
      t  = 1'($urandom % 2);
      pc = 32'h6000_0000 + 32'(($urandom % 4) * 64) + 32'(($urandom % 16) * 4);
      p  = FW'($urandom % 16);
      fill(t, pc, ($urandom % 4) == 0);
      look(t, pc, p);
    end
    #2;
    chk("R6 no extra drops", 32'(drop_count), 32'(exp_drop));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule